// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked system use an external asynchronous static RAM of 256K words by 4 bits. On the user side, a request carries an 18-bit word address, a write flag and 4 bits of write data. It is taken only in a cycle where `req_ready` is high. A read returns its data on `rsp_rdata` together with a one-cycle `rsp_valid` strobe.

On the memory side the block drives the address and three active-low strobes: chip select, write strobe and output enable. It also drives the outgoing data nibble and a drive-enable for the shared data bus. The incoming nibble is sampled on a clock edge. Each strobe comes from a register, and strobe combinations follow the memory's mode table.

Every memory timing limit is stored in nanoseconds for the selected speed grade (10, 12 or 15 ns). Each limit is rounded up to whole periods of `CLK_PS`, so one source serves any clock rate. With the defaults (8000 ps clock, 10 ns grade) the counts are:

| Item | Cycles |
|------|--------|
| Read access, including one capture margin cycle | 3 |
| Bus release after a read | 1 |
| Write strobe low | 2 |
| Drive delay after the write strobe falls | 1 |

Top module: `asram_ctrl`

## Requirements
- R1: After reset, `req_ready`=1, `mem_ce_n`=`mem_we_n`=`mem_oe_n`=1, `mem_dq_oe`=0 and `rsp_valid`=0.
- R2: A read request (`req_we`=0) accepted at edge k gives `mem_ce_n`=0, `mem_oe_n`=0, `mem_we_n`=1 and `mem_addr` equal to the request address from edge k. These hold, with the address unchanged, until the read ends.
- R3: For a read accepted at edge k, `rsp_valid` is 1 for exactly one cycle after edge k+RD_LEN. `rsp_rdata` then holds the bus value sampled at that edge. RD_LEN is max(read cycle, ceil(max access time)+1) in clocks, which is 3 with the defaults.
- R4: A write request (`req_we`=1) gives `mem_ce_n`=0, `mem_we_n`=0 and `mem_oe_n`=1, with `mem_addr` and `mem_dq_out` equal to the request address and data.
- R5: `mem_dq_oe` stays 0 for ceil(write-to-float time) cycles after `mem_we_n` falls, which is 1 with the defaults. After that it stays 1 until the write ends. It is 1 for at least ceil(data setup) sampled cycles before `mem_we_n` rises.
- R6: `mem_we_n` stays low for WR_LEN cycles. WR_LEN is the largest of the write pulse, cycle, chip-select and address-valid minimums and the drive delay plus data setup, all in clocks (2 with the defaults). It then rises one cycle before `mem_ce_n` rises.
- R7: `mem_ce_n` is 1 whenever `req_ready` is 1. `req_ready` is 0 from acceptance until the access completes: 3 cycles for a write with the defaults. A request made while `req_ready` is 0 is ignored and does not change memory contents.
- R8: After the read data is captured, `mem_ce_n` and `mem_oe_n` are 1 for ceil(max output float time) cycles before `req_ready` returns. A read therefore keeps `req_ready` low for 4 cycles with the defaults.
- R9: `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R10: Cycle counts follow `CLK_PS` and `GRADE`. At 4000 ps and grade 15, read data is valid 5 cycles after acceptance, `mem_we_n` is low for 4 cycles, and `mem_dq_oe` is 0 for the first 2 of those cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; request taken this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 4 | Read data |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | 4 | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 4 | Data sampled from the memory bus |

## Verification
The test patterns are:
- **Isolated writes and reads:** each write is read back, which separates correct strobe sequencing from address or data mixups.
- **Unwritten addresses:** the memory model returns an address-dependent value, so a stale capture register cannot pass.
- **Back-to-back mixes:** read after read, write after read and read after write, at the lowest and highest addresses, with data of all zeros and all ones. These test bus turnaround and busy-time counts separately from data paths.
- **Request during a busy write:** this shows whether the controller ever samples requests outside idle.
- **Faster-clock instance:** a second instance at 4000 ps shows whether the cycle counts really come from the nanosecond limits.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef struct packed {
      int unsigned rc;
      int unsigned aa;
      int unsigned ace;
      int unsigned aoe;
      int unsigned wc;
      int unsigned cw;
      int unsigned aw;
      int unsigned wp;
      int unsigned ds;
      int unsigned hzwe;
      int unsigned hzoe;
      int unsigned hzce;
   } asram_tim_t;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RD   = 3'd1,
      ST_TURN = 3'd2,
      ST_WR   = 3'd3,
      ST_WEND = 3'd4
   } asram_st_e;

   // Limits in ns per speed grade; the write pulse is the output-disabled one.
   function automatic asram_tim_t grade_tim(input int unsigned grade);
      asram_tim_t t;
      case (grade)
         12:      t = '{rc:12, aa:12, ace:12, aoe:6, wc:12, cw:10, aw:10,
                        wp:10, ds:7, hzwe:7, hzoe:6, hzce:6};
         15:      t = '{rc:15, aa:15, ace:15, aoe:6, wc:15, cw:11, aw:11,
                        wp:11, ds:7, hzwe:7, hzoe:6, hzce:7};
         default: t = '{rc:10, aa:10, ace:10, aoe:6, wc:10, cw:10, aw:10,
                        wp:9,  ds:7, hzwe:7, hzoe:6, hzce:6};
      endcase
      return t;
   endfunction

   function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ps);
      return (ns * 1000 + clk_ps - 1) / clk_ps;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/asram_tcnt.sv
module asram_tcnt #(
   parameter int unsigned W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] CMAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (clr)        cnt <= '0;
      else if (cnt != CMAX) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
   parameter int unsigned AW = 18,
   parameter int unsigned DW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic          cap,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic [DW-1:0] mem_dq_in,
   output logic [AW-1:0] addr_q,
   output logic [DW-1:0] wdata_q,
   output logic [DW-1:0] rdata_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rdata_q <= '0;
      else if (cap) rdata_q <= mem_dq_in;
   end
endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
   import asram_pkg::*;
#(
   parameter int unsigned RD_LEN   = 3,
   parameter int unsigned TURN_LEN = 1,
   parameter int unsigned WR_LEN   = 2,
   parameter int unsigned DRV_DLY  = 1,
   parameter int unsigned CNT_W    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_we,
   input  logic [CNT_W-1:0] cnt,
   output logic             cnt_clr,
   output logic             accept,
   output logic             cap,
   output logic             req_ready,
   output logic             rsp_valid,
   output logic             ce_n,
   output logic             we_n,
   output logic             oe_n,
   output logic             dq_oe
);
   localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_LEN - 1);
   localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(WR_LEN - 1);
   localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'((TURN_LEN == 0) ? 0 : TURN_LEN - 1);
   localparam asram_st_e        RD_EXIT   = (TURN_LEN == 0) ? ST_IDLE : ST_TURN;

   asram_st_e        st, nxt;
   logic [CNT_W-1:0] cnt_nxt;
   logic             drv_ok;

   always_comb begin
      nxt     = st;
      cnt_clr = 1'b0;
      accept  = 1'b0;
      cap     = 1'b0;
      unique case (st)
         ST_IDLE: if (req_valid) begin
            accept  = 1'b1;
            cnt_clr = 1'b1;
            nxt     = req_we ? ST_WR : ST_RD;
         end
         ST_RD: if (cnt == RD_LAST) begin
            cap     = 1'b1;
            cnt_clr = 1'b1;
            nxt     = RD_EXIT;
         end
         ST_TURN: if (cnt == TURN_LAST) begin
            cnt_clr = 1'b1;
            nxt     = ST_IDLE;
         end
         ST_WR: if (cnt == WR_LAST) begin
            cnt_clr = 1'b1;
            nxt     = ST_WEND;
         end
         ST_WEND: begin
            cnt_clr = 1'b1;
            nxt     = ST_IDLE;
         end
         default: begin
            cnt_clr = 1'b1;
            nxt     = ST_IDLE;
         end
      endcase
      cnt_nxt = cnt_clr ? '0 : cnt + 1'b1;
   end

   // Bus drive delay variant: none, or wait for the float time in cycles.
   generate
      if (DRV_DLY == 0) begin : g_drv_now
         assign drv_ok = 1'b1;
      end else begin : g_drv_wait
         localparam logic [CNT_W-1:0] DRV_C = CNT_W'(DRV_DLY);
         assign drv_ok = (cnt_nxt >= DRV_C);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         req_ready <= 1'b1;
         rsp_valid <= 1'b0;
         ce_n      <= 1'b1;
         we_n      <= 1'b1;
         oe_n      <= 1'b1;
         dq_oe     <= 1'b0;
      end else begin
         st        <= nxt;
         req_ready <= (nxt == ST_IDLE);
         rsp_valid <= cap;
         ce_n      <= !((nxt == ST_RD) || (nxt == ST_WR) || (nxt == ST_WEND));
         oe_n      <= (nxt != ST_RD);
         we_n      <= (nxt != ST_WR);
         dq_oe     <= ((nxt == ST_WR) && drv_ok) || (nxt == ST_WEND);
      end
   end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int unsigned ADDR_W    = 18,
   parameter int unsigned DATA_W    = 4,
   parameter int unsigned CLK_PS    = 8000,
   parameter int unsigned GRADE     = 10,
   parameter int unsigned RD_MARGIN = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);
   localparam asram_tim_t  TIM      = grade_tim(GRADE);
   localparam int unsigned ACC_CYC  = umax(umax(ns2cyc(TIM.aa, CLK_PS), ns2cyc(TIM.ace, CLK_PS)),
                                           ns2cyc(TIM.aoe, CLK_PS));
   localparam int unsigned RD_LEN   = umax(ACC_CYC + RD_MARGIN, ns2cyc(TIM.rc, CLK_PS));
   localparam int unsigned TURN_LEN = umax(ns2cyc(TIM.hzoe, CLK_PS), ns2cyc(TIM.hzce, CLK_PS));
   localparam int unsigned DRV_DLY  = ns2cyc(TIM.hzwe, CLK_PS);
   localparam int unsigned WR_LEN   = umax(umax(umax(ns2cyc(TIM.wp, CLK_PS), DRV_DLY + ns2cyc(TIM.ds, CLK_PS)),
                                                umax(ns2cyc(TIM.wc, CLK_PS), ns2cyc(TIM.cw, CLK_PS))),
                                           umax(ns2cyc(TIM.aw, CLK_PS), 1));
   localparam int unsigned CNT_MAX  = umax(umax(RD_LEN, WR_LEN), TURN_LEN);
   localparam int unsigned CNT_W    = $clog2(CNT_MAX + 2);

   generate
      if (GRADE != 10 && GRADE != 12 && GRADE != 15) begin : g_bad_grade
         $error("asram_ctrl: GRADE must be 10, 12 or 15");
      end
      if (CLK_PS == 0) begin : g_bad_clk
         $error("asram_ctrl: CLK_PS must be non-zero");
      end
      if (ADDR_W == 0 || DATA_W == 0) begin : g_bad_width
         $error("asram_ctrl: widths must be non-zero");
      end
   endgenerate

   logic             cnt_clr, accept, cap;
   logic [CNT_W-1:0] cnt;

   asram_tcnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .cnt   (cnt)
   );

   asram_fsm #(
      .RD_LEN   (RD_LEN),
      .TURN_LEN (TURN_LEN),
      .WR_LEN   (WR_LEN),
      .DRV_DLY  (DRV_DLY),
      .CNT_W    (CNT_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_we    (req_we),
      .cnt       (cnt),
      .cnt_clr   (cnt_clr),
      .accept    (accept),
      .cap       (cap),
      .req_ready (req_ready),
      .rsp_valid (rsp_valid),
      .ce_n      (mem_ce_n),
      .we_n      (mem_we_n),
      .oe_n      (mem_oe_n),
      .dq_oe     (mem_dq_oe)
   );

   asram_dpath #(.AW(ADDR_W), .DW(DATA_W)) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .cap       (cap),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .mem_dq_in (mem_dq_in),
      .addr_q    (mem_addr),
      .wdata_q   (mem_dq_out),
      .rdata_q   (rsp_rdata)
   );
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk
   import asram_pkg::*;
#(
   parameter int unsigned ADDR_W = 18,
   parameter int unsigned CLK_PS = 8000,
   parameter int unsigned GRADE  = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              mem_ce_n,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic              mem_dq_oe,
   input logic [ADDR_W-1:0] mem_addr
);
   localparam asram_tim_t  TIM    = grade_tim(GRADE);
   localparam int unsigned WP_CYC = ns2cyc(TIM.wp, CLK_PS);
   localparam int unsigned DS_CYC = ns2cyc(TIM.ds, CLK_PS);
   localparam int unsigned AC_CYC = umax(umax(ns2cyc(TIM.aa, CLK_PS), ns2cyc(TIM.ace, CLK_PS)),
                                         ns2cyc(TIM.aoe, CLK_PS));

   logic [7:0] we_lo_cnt, dq_on_cnt, oe_lo_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_lo_cnt <= '0;
         dq_on_cnt <= '0;
         oe_lo_cnt <= '0;
      end else begin
         we_lo_cnt <= mem_we_n ? 8'd0 : ((we_lo_cnt == 8'hFF) ? we_lo_cnt : we_lo_cnt + 8'd1);
         dq_on_cnt <= (mem_we_n || !mem_dq_oe) ? 8'd0 :
                      ((dq_on_cnt == 8'hFF) ? dq_on_cnt : dq_on_cnt + 8'd1);
         oe_lo_cnt <= (!mem_oe_n) ? ((oe_lo_cnt == 8'hFF) ? oe_lo_cnt : oe_lo_cnt + 8'd1) :
                      (rsp_valid ? oe_lo_cnt : 8'd0);
      end
   end

   AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe)); // R1
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce_n |=> (mem_ce_n || $stable(mem_addr))); // R2
   AST_RSP_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_valid) |-> (oe_lo_cnt >= 8'(AC_CYC))); // R3
   AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R3
   AST_WRITE_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_oe_n && !mem_ce_n)); // R4
   AST_DATA_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (dq_on_cnt >= 8'(DS_CYC))); // R5
   AST_WE_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_lo_cnt >= 8'(WP_CYC))); // R6
   AST_WE_BEFORE_CE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> !mem_ce_n); // R6
   AST_CE_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> mem_ce_n); // R7
   AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_dq_oe && !mem_oe_n)); // R9
endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .CLK_PS(CLK_PS), .GRADE(GRADE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .mem_ce_n  (mem_ce_n),
   .mem_we_n  (mem_we_n),
   .mem_oe_n  (mem_oe_n),
   .mem_dq_oe (mem_dq_oe),
   .mem_addr  (mem_addr)
);

// File: tb/tb_asram_ctrl.sv
module tb_asram_ctrl;
   localparam int RD_LAT  = 3;  // R3
   localparam int RD_BUSY = 4;  // R8
   localparam int WR_BUSY = 3;  // R7

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_we = 1'b0;
   logic [17:0] req_addr = '0;
   logic [3:0]  req_wdata = '0;
   logic        req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [3:0]  rsp_rdata, mem_dq_out;
   logic [3:0]  mem_dq_in = '0;
   logic [17:0] mem_addr;

   // second instance: 4000 ps timing, grade 15
   logic        b_valid = 1'b0, b_we = 1'b0;
   logic        b_ready, b_rsp, b_ce_n, b_we_n, b_oe_n, b_dq_oe;
   logic [3:0]  b_rdata, b_dq_out;
   logic [17:0] b_addr;

   int checks = 0, errors = 0, cyc = 0;
   int fight_cnt = 0, ce_idle_cnt = 0;
   bit done = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   asram_ctrl dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
      .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   asram_ctrl #(.CLK_PS(4000), .GRADE(15)) dut_fast (
      .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_ready(b_ready),
      .req_we(b_we), .req_addr(18'd7), .req_wdata(4'h3),
      .rsp_valid(b_rsp), .rsp_rdata(b_rdata), .mem_addr(b_addr),
      .mem_ce_n(b_ce_n), .mem_we_n(b_we_n), .mem_oe_n(b_oe_n),
      .mem_dq_out(b_dq_out), .mem_dq_oe(b_dq_oe), .mem_dq_in(4'hA)
   );

   function automatic logic [3:0] init_val(input logic [17:0] a);
      return 4'(a ^ (a >> 5));
   endfunction

   // external memory model
   logic [3:0] marr [int];
   always @(posedge mem_we_n)
      if (mem_ce_n === 1'b0 && mem_dq_oe === 1'b1) marr[int'(mem_addr)] = mem_dq_out;
   always @(negedge clk)
      if (mem_ce_n === 1'b0 && mem_oe_n === 1'b0 && mem_we_n === 1'b1)
         mem_dq_in <= marr.exists(int'(mem_addr)) ? marr[int'(mem_addr)] : init_val(mem_addr);
      else
         mem_dq_in <= 4'h0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // scoreboard
   logic [3:0] shadow [int];
   logic [3:0] exp_q[$];
   int         t_q[$];

   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_dq_oe && !mem_oe_n) fight_cnt++;
         if (req_ready && !mem_ce_n) ce_idle_cnt++;
         if (rsp_valid) begin
            if (exp_q.size() == 0) chk(0, "R3", "unexpected rsp_valid", 1, 0);
            else begin
               logic [3:0] e;
               int t;
               e = exp_q.pop_front();
               t = t_q.pop_front();
               chk(rsp_rdata == e, "R3", "read data", int'(rsp_rdata), int'(e));
               chk(cyc - t == RD_LAT, "R3", "read latency", cyc - t, RD_LAT);
            end
         end
      end
   end

   task automatic do_req(input logic we, input logic [17:0] a, input logic [3:0] d);
      int n;
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      if (!we) begin
         exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : init_val(a));
         t_q.push_back(cyc);
         chk(!mem_ce_n && !mem_oe_n && mem_we_n && mem_addr == a, "R2", "read strobes/addr",
             int'({mem_ce_n, mem_oe_n, mem_we_n}), 3'b001);
      end else begin
         shadow[int'(a)] = d;
         chk(!mem_ce_n && !mem_we_n && mem_oe_n && mem_addr == a, "R4", "write strobes/addr",
             int'({mem_ce_n, mem_oe_n, mem_we_n}), 3'b010);
         chk(!mem_dq_oe, "R5", "no drive in first write cycle", int'(mem_dq_oe), 0);
      end
      n = 0;
      while (!req_ready) begin
         n++;
         if (we && n == 2) chk(mem_dq_oe && !mem_we_n && mem_dq_out == d, "R5", "drive data",
                               int'(mem_dq_out), int'(d));
         if (we && n == 3) chk(mem_we_n && !mem_ce_n, "R6", "strobe rises before select",
                               int'({mem_ce_n, mem_we_n}), 2'b01);
         if (!we && n == 2) chk(!mem_ce_n && !mem_oe_n && mem_addr == a, "R2", "read held",
                                int'(mem_addr), int'(a));
         if (!we && n == 4) chk(mem_ce_n && mem_oe_n, "R8", "turnaround strobes high",
                                int'({mem_ce_n, mem_oe_n}), 2'b11);
         @(negedge clk);
      end
      if (we) chk(n == WR_BUSY, "R7", "write busy cycles", n, WR_BUSY);
      else    chk(n == RD_BUSY, "R8", "read busy cycles", n, RD_BUSY);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish actual=0 expected=1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid, "R1",
          "reset state", int'({req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid}), 6'b111100);

      do_req(1'b1, 18'h00015, 4'h5);
      do_req(1'b0, 18'h00015, 4'h0);
      do_req(1'b0, 18'h00123, 4'h0);           // unwritten
      do_req(1'b1, 18'h00000, 4'hF);
      do_req(1'b1, 18'h3FFFF, 4'h0);
      do_req(1'b0, 18'h3FFFF, 4'h0);
      do_req(1'b0, 18'h00000, 4'h0);
      do_req(1'b1, 18'h2A5A5, 4'hA);           // write after read
      do_req(1'b0, 18'h2A5A5, 4'h0);

      // R7: request while busy is ignored
      fork
         do_req(1'b1, 18'h00100, 4'h9);
         begin
            @(negedge clk); @(negedge clk);
            chk(!req_ready, "R7", "busy during poke", int'(req_ready), 0);
            req_valid = 1'b1; req_we = 1'b1; req_addr = 18'h00200; req_wdata = 4'hF;
            @(negedge clk);
            req_valid = 1'b0;
         end
      join
      do_req(1'b0, 18'h00200, 4'h0);
      do_req(1'b0, 18'h00100, 4'h0);
      repeat (6) @(negedge clk);
      chk(exp_q.size() == 0, "R3", "all reads answered", exp_q.size(), 0);
      chk(fight_cnt == 0, "R9", "drive while output enabled", fight_cnt, 0);
      chk(ce_idle_cnt == 0, "R7", "select low while ready", ce_idle_cnt, 0);

      // R10: fast-clock instance
      begin
         int lat, lo, lo_nodrv;
         b_valid = 1'b1; b_we = 1'b0;
         @(negedge clk);
         b_valid = 1'b0;
         lat = 0;
         while (!b_rsp && lat < 50) begin lat++; @(negedge clk); end
         chk(lat == 5, "R10", "fast read latency", lat, 5);
         chk(b_rdata == 4'hA, "R10", "fast read data", int'(b_rdata), 10);
         while (!b_ready) @(negedge clk);
         b_valid = 1'b1; b_we = 1'b1;
         @(negedge clk);
         b_valid = 1'b0;
         lo = 0; lo_nodrv = 0;
         while (!b_we_n && lo < 50) begin
            lo++;
            if (!b_dq_oe) lo_nodrv++;
            @(negedge clk);
         end
         chk(lo == 4, "R10", "fast write strobe low", lo, 4);
         chk(lo_nodrv == 2, "R10", "fast drive delay", lo_nodrv, 2);
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule